// File: doc/BRIEF.md
# Link Transfer Error Monitor

This block watches the result of every data transfer that arrives over an internal link, one transfer per scan strobe. A clean transfer updates the data word given to downstream logic. A transfer marked bad is thrown away, and the last good word stays on the output in its place. This way a single corrupted transfer never reaches the consumer.

A saturating run counter gives the block hysteresis in both directions. A fixed number of bad transfers in a row (four by default) raises a persistent failure signal. Downstream averaging filters also use this signal as their reset. The same number of good transfers in a row clears it again. The persistent failure is combined with a supply-missing status and a startup-wait status into one active-low error flag. That flag is registered, it is low out of reset, and it goes high only once all three causes are inactive.

The asynchronous reset takes effect at once, and its release is synchronised to the clock through two flops.

Top module: `xfer_err_monitor`

## Requirements
- R1: On a clock edge where `scan_strobe` is 1 and `xfer_bad` is 0, `good_data` takes the value of `rx_word` in the following cycle.
- R2: On a clock edge where `scan_strobe` is 1 and `xfer_bad` is 1, `good_data` keeps its previous value.
- R3: On a clock edge where `scan_strobe` is 0, neither `good_data` nor the run count changes, whatever `xfer_bad` and `rx_word` are. A run of bad strobes separated by idle cycles still counts as consecutive.
- R4: While `link_fail` is 0, the RUN_LEN-th consecutive strobe with `xfer_bad`=1 sets `link_fail` to 1 in the next cycle. It does not set earlier than that.
- R5: Any strobe whose result matches the current `link_fail` state (bad while failed, good while not failed) restarts the run count. So 3 bad, 1 good, 3 bad does not set `link_fail`.
- R6: While `link_fail` is 1, the RUN_LEN-th consecutive strobe with `xfer_bad`=0 clears `link_fail` in the next cycle. Bad strobes during that time keep the last good word on `good_data`.
- R7: `err_n` equals NOT(`link_fail` OR `supply_missing` OR `startup_wait`), taken from the values of the previous cycle, so it has one register of latency.
- R8: While reset is active and for two cycles after its release, `good_data` is 0, `link_fail` is 0 and `err_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scan_strobe | input | 1 | Marks the cycle in which a transfer result is valid |
| xfer_bad | input | 1 | 1 when the current transfer failed its check |
| rx_word | input | DATA_W (8) | Received data word of the current transfer |
| supply_missing | input | 1 | Sensor-side supply missing status, active high |
| startup_wait | input | 1 | Link still waiting for its startup, active high |
| good_data | output | DATA_W (8) | Last word received without error |
| link_fail | output | 1 | Persistent failure, also used as filter reset |
| err_n | output | 1 | Combined error flag, active low |

## Verification
Two things can happen on the same strobe: the strobe that completes a run toggles `link_fail`, and the same strobe either loads `good_data` (clean) or holds it (bad). The bench builds runs of exactly RUN_LEN bad strobes and RUN_LEN good strobes. It also checks the word on that final strobe against the word on the strobe before it, and checks `err_n` one cycle later against the new failure state. Random bursts vary the strobe density and the error bias so that completed and broken runs often meet idle gaps. A bench model predicts all three outputs every cycle.

// File: rtl/xem_pkg.sv
package xem_pkg;

  typedef enum logic {
    LINK_OK   = 1'b0,
    LINK_DOWN = 1'b1
  } link_state_e;

  function automatic logic err_flag_n(input logic fail, input logic supply_missing,
                                      input logic startup_wait);
    return ~(fail | supply_missing | startup_wait);
  endfunction

endpackage

// File: rtl/xem_run_counter.sv
module xem_run_counter
  import xem_pkg::*;
#(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic bad,
  output logic fail
);
  localparam int CNT_W = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

  link_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             opposite;

  // a transfer counts toward a flip only when it disagrees with the current state
  assign opposite = (state_q == LINK_DOWN) ? ~bad : bad;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (strobe) begin
      if (!opposite) begin
        cnt_d = '0;
      end else if (cnt_q == LAST) begin
        cnt_d   = '0;
        state_d = (state_q == LINK_DOWN) ? LINK_OK : LINK_DOWN;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LINK_OK;
      cnt_q   <= '0;
    end else if (strobe) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign fail = (state_q == LINK_DOWN);

endmodule

// File: rtl/xem_data_hold.sv
module xem_data_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              bad,
  input  logic [DATA_W-1:0] word_in,
  output logic [DATA_W-1:0] word_out
);
  logic              load_en;
  logic [DATA_W-1:0] word_q;

  assign load_en = strobe & ~bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (load_en) begin
      word_q <= word_in;
    end
  end

  assign word_out = word_q;

endmodule

// File: rtl/xem_err_combine.sv
module xem_err_combine
  import xem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fail,
  input  logic supply_missing,
  input  logic startup_wait,
  output logic err_n
);
  logic err_n_q, err_n_d;

  always_comb begin
    err_n_d = err_flag_n(fail, supply_missing, startup_wait);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_n_q <= 1'b0;
    end else begin
      err_n_q <= err_n_d;
    end
  end

  assign err_n = err_n_q;

endmodule

// File: rtl/xfer_err_monitor.sv
module xfer_err_monitor #(
  parameter int DATA_W  = 8,
  parameter int RUN_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_strobe,
  input  logic              xfer_bad,
  input  logic [DATA_W-1:0] rx_word,
  input  logic              supply_missing,
  input  logic              startup_wait,
  output logic [DATA_W-1:0] good_data,
  output logic              link_fail,
  output logic              err_n
);
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_sync_q[1];

  xem_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .strobe (scan_strobe),
    .bad    (xfer_bad),
    .fail   (link_fail)
  );

  xem_data_hold #(.DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .strobe   (scan_strobe),
    .bad      (xfer_bad),
    .word_in  (rx_word),
    .word_out (good_data)
  );

  xem_err_combine u_comb (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .fail           (link_fail),
    .supply_missing (supply_missing),
    .startup_wait   (startup_wait),
    .err_n          (err_n)
  );

endmodule

// File: rtl/xem_checker.sv
module xem_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              scan_strobe,
  input logic              xfer_bad,
  input logic [DATA_W-1:0] rx_word,
  input logic              supply_missing,
  input logic              startup_wait,
  input logic [DATA_W-1:0] good_data,
  input logic              link_fail,
  input logic              err_n
);
  p_load_clean_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (scan_strobe && !xfer_bad) |=> (good_data == $past(rx_word)));

  p_hold_bad_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (scan_strobe && xfer_bad) |=> $stable(good_data));

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !scan_strobe |=> ($stable(good_data) && $stable(link_fail)));

  p_set_on_bad_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(link_fail) |-> $past(scan_strobe && xfer_bad));

  p_clear_on_good_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(link_fail) |-> $past(scan_strobe && !xfer_bad));

  p_flag_nor_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (err_n == !($past(link_fail) || $past(supply_missing) || $past(startup_wait))));

endmodule

bind xfer_err_monitor xem_checker #(.DATA_W(DATA_W)) u_xem_checker (
  .clk            (clk),
  .rst_sync_n     (rst_sync_n),
  .scan_strobe    (scan_strobe),
  .xfer_bad       (xfer_bad),
  .rx_word        (rx_word),
  .supply_missing (supply_missing),
  .startup_wait   (startup_wait),
  .good_data      (good_data),
  .link_fail      (link_fail),
  .err_n          (err_n)
);

// File: tb/test_xfer_err_monitor.sv
module test_xfer_err_monitor;
  localparam int DW  = 8;
  localparam int RUN = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          scan_strobe, xfer_bad, supply_missing, startup_wait;
  logic [DW-1:0] rx_word;
  logic [DW-1:0] good_data;
  logic          link_fail, err_n;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model
  logic [DW-1:0] e_data;
  logic          e_fail, e_errn;
  int            e_cnt;

  always #5 clk = ~clk;

  xfer_err_monitor #(.DATA_W(DW), .RUN_LEN(RUN)) i_xfer_err_monitor (
    .clk(clk), .rst_n(rst_n), .scan_strobe(scan_strobe), .xfer_bad(xfer_bad),
    .rx_word(rx_word), .supply_missing(supply_missing), .startup_wait(startup_wait),
    .good_data(good_data), .link_fail(link_fail), .err_n(err_n)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all(input string rd, input string rf, input string re);
    check(rd, "good_data", int'(good_data), int'(e_data));
    check(rf, "link_fail", int'(link_fail), int'(e_fail));
    check(re, "err_n", int'(err_n), int'(e_errn));
  endtask

  // drive one cycle: set inputs at the negedge, update model, then check after the edge
  task automatic step(input logic s, input logic b, input logic [DW-1:0] w,
                      input logic sm, input logic sw,
                      input string rd, input string rf, input string re);
    scan_strobe = s; xfer_bad = b; rx_word = w; supply_missing = sm; startup_wait = sw;
    e_errn = ~(e_fail | sm | sw);
    if (s) begin
      if (!b) e_data = w;
      if (b != e_fail) begin
        if (e_cnt == RUN - 1) begin e_cnt = 0; e_fail = ~e_fail; end
        else e_cnt++;
      end else e_cnt = 0;
    end
    @(negedge clk);
    check_all(rd, rf, re);
  endtask

  initial begin
    #(150000 * 10);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic bias;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; scan_strobe = 0; xfer_bad = 0; rx_word = '0;
    supply_missing = 0; startup_wait = 1;
    e_data = '0; e_fail = 0; e_errn = 0; e_cnt = 0;
    repeat (3) @(negedge clk);
    check_all("R8", "R8", "R8");
    rst_n = 1'b1;
    // reset release takes two cycles to reach the logic; inputs keep flag low
    @(negedge clk); check_all("R8", "R8", "R8");
    @(negedge clk); check_all("R8", "R8", "R8");

    // startup completes: flag rises one cycle later
    step(0, 0, 8'h00, 0, 1, "R8", "R8", "R7");
    step(0, 0, 8'h00, 0, 0, "R3", "R3", "R7");
    step(0, 0, 8'h00, 0, 0, "R3", "R3", "R7");
    // clean loads
    step(1, 0, 8'hA5, 0, 0, "R1", "R1", "R7");
    step(1, 0, 8'h3C, 0, 0, "R1", "R1", "R7");
    // bad transfer holds the word
    step(1, 1, 8'hFF, 0, 0, "R2", "R2", "R7");
    // idle cycles with junk do nothing
    step(0, 1, 8'h11, 0, 0, "R3", "R3", "R3");
    step(0, 0, 8'h22, 0, 0, "R3", "R3", "R3");
    // broken run: 1 bad above + 2 more, then clean, then 3 bad -> no set
    step(1, 1, 8'h01, 0, 0, "R5", "R5", "R7");
    step(1, 1, 8'h02, 0, 0, "R5", "R5", "R7");
    step(1, 0, 8'h5A, 0, 0, "R5", "R5", "R7");
    for (int i = 0; i < 3; i++) step(1, 1, 8'h70 + DW'(i), 0, 0, "R5", "R5", "R7");
    // fourth bad with idle gap before it: set
    step(0, 0, 8'h00, 0, 0, "R3", "R3", "R3");
    step(1, 1, 8'h99, 0, 0, "R4", "R4", "R7");
    step(0, 0, 8'h00, 0, 0, "R4", "R4", "R7");
    // recovery: three good, one bad breaks it, then four good clears
    for (int i = 0; i < 3; i++) step(1, 0, 8'h40 + DW'(i), 0, 0, "R6", "R6", "R7");
    step(1, 1, 8'hEE, 0, 0, "R6", "R6", "R7");
    for (int i = 0; i < 4; i++) step(1, 0, 8'h80 + DW'(i), 0, 0, "R6", "R6", "R7");
    step(0, 0, 8'h00, 0, 0, "R6", "R6", "R7");
    // supply missing alone pulls the flag low
    step(0, 0, 8'h00, 1, 0, "R3", "R3", "R7");
    step(0, 0, 8'h00, 0, 0, "R3", "R3", "R7");
    step(0, 0, 8'h00, 0, 0, "R3", "R3", "R7");

    // random bursts
    bias = 0;
    for (int i = 0; i < 4000; i++) begin
      if (i % 24 == 0) bias = $urandom % 2;
      step(($urandom % 3) != 0,
           bias ? (($urandom % 8) != 0) : (($urandom % 8) == 0),
           DW'($urandom),
           ($urandom % 64) == 0, ($urandom % 97) == 0,
           "R1", "R5", "R7");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule